// File: doc/BRIEF.md
# APB address fan-out interconnect

This block sits between a single upstream APB requester and eleven downstream APB targets. Each upstream transfer is steered to exactly one target, picked from a fixed address region. The address, write data and direction go to every target port, but only the selected port sees PSEL and PENABLE. The selected target's read data, ready and error come back upstream. Addresses that hit no target complete at once with an error.

The block also works with an external ready-timeout counter. In the setup phase of every transfer to a mapped target, it raises a one-cycle start pulse that arms the counter. If the counter's expiry pulse arrives while the transfer is still open, the block ends that transfer with an error and drops the target's select. One cycle later it raises a single bit in a 12-bit flag vector, which names the target that failed to answer.

Top module: `apb_fan_xbar`

## Requirements
- R1: The region selector is `s_paddr[11:8]`. Values 0 to 10 select target ports 0 to 10 in this order: clock generator, GPIO, DMA, system control, advanced timer, event generator, I2C target, timer, FPGA fabric, debug, console. At most one `m_psel` bit is high, and it is the bit whose index equals the region.
- R2: Every target port carries the upstream address, write data and write direction. `m_penable[t]` is high only in the access phase of a transfer whose setup phase raised `m_psel[t]`.
- R3: A transfer to a mapped region returns the selected port's `m_prdata`, `m_pready` and `m_pslverr` upstream, and passes through any wait states the target inserts.
- R4: A transfer to regions 11 to 15 raises no `m_psel`. Its access phase completes in one cycle with `s_pready`=1, `s_pslverr`=1 and `s_prdata`=0.
- R5: `tmo_start_o` is high for exactly the setup-phase cycle (`s_psel`=1, `s_penable`=0) of a transfer to a mapped region. It is low in access and wait cycles, and low for unmapped regions.
- R6: If `tmo_expire_i` is high during the access phase of a mapped transfer, the transfer completes in that cycle with `s_pready`=1, `s_pslverr`=1 and `s_prdata`=0. In the same cycle the target's `m_psel` and `m_penable` are low.
- R7: If `tmo_expire_i` is high during the setup phase of a mapped transfer, the target's `m_psel` is low from that cycle on. The following access cycle completes at once with `s_pready`=1, `s_pslverr`=1 and `s_prdata`=0, and no `m_penable` rises.
- R8: A timeout (R6 or R7) sets exactly one bit of `tmo_flags_o` in the next cycle, for one cycle. Regions 0 to 8 set bits 0 to 8. Region 9 (debug) sets bit 10. Region 10 (console) sets bit 9. Bit 11 is never set.
- R9: `tmo_expire_i` has no effect when no transfer is open or when the open transfer is to an unmapped region. In that case `tmo_flags_o` stays 0.
- R10: Reset is synchronous and active low. While `rst_n` is 0, all `m_psel` and `m_penable` bits and `tmo_start_o` are 0. After the first clock edge in reset, `tmo_flags_o` is 0.
- R11: If a target signals ready in the same access cycle as `tmo_expire_i`, the timeout wins: `s_pslverr`=1 and the flag of R8 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_paddr | input | 12 | Upstream address |
| s_pwdata | input | 32 | Upstream write data |
| s_pwrite | input | 1 | Upstream write direction |
| s_psel | input | 1 | Upstream select |
| s_penable | input | 1 | Upstream enable |
| s_prdata | output | 32 | Read data returned upstream |
| s_pready | output | 1 | Ready returned upstream |
| s_pslverr | output | 1 | Error returned upstream |
| m_paddr | output | 11x12 | Address to each target |
| m_pwdata | output | 11x32 | Write data to each target |
| m_pwrite | output | 11 | Write direction to each target |
| m_psel | output | 11 | Select to each target |
| m_penable | output | 11 | Enable to each target |
| m_prdata | input | 11x32 | Read data from each target |
| m_pready | input | 11 | Ready from each target |
| m_pslverr | input | 11 | Error from each target |
| tmo_expire_i | input | 1 | Expiry pulse from the external timeout counter |
| tmo_start_o | output | 1 | Pulse that arms the external timeout counter |
| tmo_flags_o | output | 12 | One-hot pulse naming the target that timed out |

## Verification
The bench uses the default parameters: 12-bit address, 32-bit data, and a 4-bit selector at bit 8 over 11 targets. With a 4-bit selector there are only 16 regions, so the bench sweeps every region, mapped and unmapped, in both directions. The modelled targets insert zero to two wait states, and their error bit depends on the address. Timeouts are forced on every target in both the setup and the access phase, so every entry of the swapped flag mapping is reached. The cases of an expiry pulse with no open transfer, an expiry during an unmapped transfer, and an expiry coinciding with target ready are also covered.

// File: rtl/apb_fan_pkg.sv
// Package: constants shared by the fan-out interconnect.
// Assumes exactly eleven targets. The flag-bit mapping below swaps the last two targets.
package apb_fan_pkg;
    localparam int unsigned NUM_TGT = 11;
    localparam int unsigned FLAG_W  = 12;

    // Map a target index to its position in the timeout flag vector.
    function automatic int unsigned flag_bit(input int unsigned tgt);
        case (tgt)
            9:       return 10;
            10:      return 9;
            default: return tgt;
        endcase
    endfunction
endpackage

// File: rtl/apb_fan_decode.sv
// Region decoder: turns the address selector field into a one-hot target vector.
// Assumes region values at or above NTGT are unmapped.
module apb_fan_decode #(
    parameter int unsigned SEL_W = 4,
    parameter int unsigned NTGT  = 11
) (
    input  logic [SEL_W-1:0] region,
    output logic [NTGT-1:0]  hit_vec,
    output logic             hit
);
    // One comparator per target.
    for (genvar t = 0; t < NTGT; t++) begin : g_cmp
        assign hit_vec[t] = (region == SEL_W'(t));
    end

    // Any target matched.
    assign hit = |hit_vec;
endmodule

// File: rtl/apb_fan_rto.sv
// Timeout tracker: detects an expiry pulse during an open mapped transfer,
// holds an abort state across setup-to-access, and emits a one-cycle flag pulse.
// Assumes the upstream obeys APB phase order.
module apb_fan_rto #(
    parameter int unsigned NTGT   = 11,
    parameter int unsigned FLAGS  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             expire,
    input  logic             s_psel,
    input  logic             s_penable,
    input  logic [NTGT-1:0]  hit_vec,
    input  logic             hit,
    output logic             abort_now,
    output logic [FLAGS-1:0] flags
);
    localparam int unsigned FIW = $clog2(FLAGS);

    logic             abort_q;
    logic             tmo_hit;
    logic [FLAGS-1:0] next_flags;

    // A timeout is an expiry while a mapped transfer is open and not yet aborted.
    assign tmo_hit   = expire && s_psel && hit && !abort_q;
    assign abort_now = tmo_hit || abort_q;

    // Remember an abort taken in setup so the access phase completes with error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_q <= 1'b0;
        end else if (tmo_hit && !s_penable) begin
            abort_q <= 1'b1;
        end else if (!s_psel || s_penable) begin
            abort_q <= 1'b0;
        end
    end

    // Place the timed-out target at its flag position.
    always_comb begin
        next_flags = '0;
        for (int unsigned t = 0; t < NTGT; t++) begin
            if (hit_vec[t]) begin
                next_flags[FIW'(apb_fan_pkg::flag_bit(t))] = tmo_hit;
            end
        end
    end

    // Register the flag vector as a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= next_flags;
        end
    end

    // R8: at most one flag at a time, and only right after an expiry pulse.
    assert_flag_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flags));
    assert_flag_after_expire_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flags != '0) |-> $past(expire));
endmodule

// File: rtl/apb_fan_rmux.sv
// Response mux: returns the selected target's response upstream, or an
// error completion for unmapped regions and aborted transfers.
// Assumes hit_vec is one-hot or zero.
module apb_fan_rmux #(
    parameter int unsigned NTGT   = 11,
    parameter int unsigned DATA_W = 32
) (
    input  logic [NTGT-1:0]             hit_vec,
    input  logic                        hit,
    input  logic                        abort_now,
    input  logic [NTGT-1:0][DATA_W-1:0] m_prdata,
    input  logic [NTGT-1:0]             m_pready,
    input  logic [NTGT-1:0]             m_pslverr,
    output logic [DATA_W-1:0]           s_prdata,
    output logic                        s_pready,
    output logic                        s_pslverr
);
    // Pick the response source: abort, unmapped error, or selected target.
    always_comb begin
        s_prdata  = '0;
        s_pready  = 1'b1;
        s_pslverr = 1'b1;
        if (hit && !abort_now) begin
            s_pready  = 1'b0;
            s_pslverr = 1'b0;
            for (int unsigned t = 0; t < NTGT; t++) begin
                if (hit_vec[t]) begin
                    s_prdata  = s_prdata | m_prdata[t];
                    s_pready  = s_pready | m_pready[t];
                    s_pslverr = s_pslverr | m_pslverr[t];
                end
            end
        end
    end
endmodule

// File: rtl/apb_fan_xbar.sv
// Top: one APB requester port fanned out to NTGT APB target ports by address
// region, with a start pulse and per-target flags for an external timeout counter.
// Assumes an APB-compliant upstream and a one-cycle expiry pulse.
module apb_fan_xbar #(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned SEL_LSB = 8,
    parameter int unsigned SEL_W   = 4,
    parameter int unsigned NTGT    = apb_fan_pkg::NUM_TGT,
    parameter int unsigned FLAGS   = apb_fan_pkg::FLAG_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           s_paddr,
    input  logic [DATA_W-1:0]           s_pwdata,
    input  logic                        s_pwrite,
    input  logic                        s_psel,
    input  logic                        s_penable,
    output logic [DATA_W-1:0]           s_prdata,
    output logic                        s_pready,
    output logic                        s_pslverr,
    output logic [NTGT-1:0][ADDR_W-1:0] m_paddr,
    output logic [NTGT-1:0][DATA_W-1:0] m_pwdata,
    output logic [NTGT-1:0]             m_pwrite,
    output logic [NTGT-1:0]             m_psel,
    output logic [NTGT-1:0]             m_penable,
    input  logic [NTGT-1:0][DATA_W-1:0] m_prdata,
    input  logic [NTGT-1:0]             m_pready,
    input  logic [NTGT-1:0]             m_pslverr,
    input  logic                        tmo_expire_i,
    output logic                        tmo_start_o,
    output logic [FLAGS-1:0]            tmo_flags_o
);
    logic [NTGT-1:0] hit_vec;
    logic            hit;
    logic            abort_now;

    apb_fan_decode #(.SEL_W(SEL_W), .NTGT(NTGT)) u_decode (
        .region  (s_paddr[SEL_LSB +: SEL_W]),
        .hit_vec (hit_vec),
        .hit     (hit)
    );

    apb_fan_rto #(.NTGT(NTGT), .FLAGS(FLAGS)) u_rto (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire    (tmo_expire_i),
        .s_psel    (s_psel),
        .s_penable (s_penable),
        .hit_vec   (hit_vec),
        .hit       (hit),
        .abort_now (abort_now),
        .flags     (tmo_flags_o)
    );

    apb_fan_rmux #(.NTGT(NTGT), .DATA_W(DATA_W)) u_rmux (
        .hit_vec   (hit_vec),
        .hit       (hit),
        .abort_now (abort_now),
        .m_prdata  (m_prdata),
        .m_pready  (m_pready),
        .m_pslverr (m_pslverr),
        .s_prdata  (s_prdata),
        .s_pready  (s_pready),
        .s_pslverr (s_pslverr)
    );

    // Per-target request drive: broadcast payload, gated select and enable.
    for (genvar t = 0; t < NTGT; t++) begin : g_port
        assign m_paddr[t]   = s_paddr;
        assign m_pwdata[t]  = s_pwdata;
        assign m_pwrite[t]  = s_pwrite;
        assign m_psel[t]    = rst_n && s_psel && hit_vec[t] && !abort_now;
        assign m_penable[t] = m_psel[t] && s_penable;
    end

    // Arm the external counter in the setup phase of a mapped transfer.
    assign tmo_start_o = rst_n && s_psel && !s_penable && hit;

    // R1: never more than one target selected.
    assert_psel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_psel));
    // R2: an enabled target was selected in the previous (setup) cycle.
    assert_enable_after_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|m_penable) |-> ($past(m_psel) == m_psel));
    // R4: unmapped access phase completes with error and zero data.
    assert_unmapped_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_psel && s_penable && !hit) |-> (s_pready && s_pslverr && s_prdata == '0 && m_psel == '0));
    // R5: the start pulse never lasts two cycles.
    assert_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_start_o |=> !tmo_start_o);
    // R6: an expiry in the access phase closes the transfer with the target released.
    assert_access_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_expire_i && s_psel && s_penable) |-> (s_pready && m_psel == '0 && m_penable == '0));
    // R7: an expiry in setup makes the following access complete with error.
    assert_setup_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n && tmo_expire_i && s_psel && !s_penable && hit) && s_psel && s_penable)
        |-> (s_pready && s_pslverr && m_penable == '0));

    // R10: no target is selected while reset is held.
    always_comb begin
        if (!rst_n) begin
            assert_reset_idle_R10: assert (m_psel == '0 && m_penable == '0 && !tmo_start_o);
        end
    end
endmodule

// File: tb/apb_fan_xbar_bench.sv
// Bench: sweeps all 16 address regions in both directions with modelled
// targets, then forces timeouts on every target in both phases.
module apb_fan_xbar_bench;
    localparam int NT = 11;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [11:0]           s_paddr = '0;
    logic [31:0]           s_pwdata = '0;
    logic                  s_pwrite = 1'b0;
    logic                  s_psel = 1'b0;
    logic                  s_penable = 1'b0;
    logic [31:0]           s_prdata;
    logic                  s_pready;
    logic                  s_pslverr;
    logic [NT-1:0][11:0]   m_paddr;
    logic [NT-1:0][31:0]   m_pwdata;
    logic [NT-1:0]         m_pwrite;
    logic [NT-1:0]         m_psel;
    logic [NT-1:0]         m_penable;
    logic [NT-1:0][31:0]   m_prdata;
    logic [NT-1:0]         m_pready;
    logic [NT-1:0]         m_pslverr;
    logic                  tmo_expire_i = 1'b0;
    logic                  tmo_start_o;
    logic [11:0]           tmo_flags_o;

    int   checks = 0;
    int   fails  = 0;
    logic stall  = 1'b0;
    int   wcnt   = 0;

    apb_fan_xbar u_apb_fan_xbar (.*);

    always #2 clk = ~clk;

    // Target model: wait states = index mod 3, error = address bit 2.
    for (genvar t = 0; t < NT; t++) begin : g_tgt
        assign m_pready[t]  = m_penable[t] && !stall && (wcnt >= t % 3);
        assign m_prdata[t]  = {8'(8'hC0 + t), 12'h000, m_paddr[t]};
        assign m_pslverr[t] = m_paddr[t][2];
    end

    // Wait-state counter of the target model.
    always @(posedge clk) begin
        if (!(|m_penable) || (|(m_penable & m_pready))) wcnt <= 0;
        else wcnt <= wcnt + 1;
    end

    function automatic int fbit(input int r);
        return (r == 9) ? 10 : (r == 10) ? 9 : r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_xfer(input logic [11:0] a, input logic wr);
        int r = int'(a[11:8]);
        bit mapped = (r < NT);
        logic [NT-1:0] esel = '0;
        int waited = 0;
        if (mapped) esel[r] = 1'b1;
        @(negedge clk);
        s_paddr = a; s_pwrite = wr; s_pwdata = {20'h5A5A5, a};
        s_psel = 1'b1; s_penable = 1'b0;
        #1;
        chk(tmo_start_o == mapped, mapped ? "R5" : "R4", "start in setup", 32'(tmo_start_o), 32'(mapped));
        chk(m_psel == esel, "R1", "select vector", 32'(m_psel), 32'(esel));
        chk(m_penable == '0, "R2", "enable in setup", 32'(m_penable), 0);
        for (int t = 0; t < NT; t++) begin
            chk(m_paddr[t] == a && m_pwdata[t] == s_pwdata && m_pwrite[t] == wr,
                "R2", "broadcast payload", 32'(m_paddr[t]), 32'(a));
        end
        @(negedge clk);
        s_penable = 1'b1;
        for (int i = 0; i < 8; i++) begin
            #1;
            chk(!tmo_start_o, "R5", "start in access", 32'(tmo_start_o), 0);
            chk(m_penable == esel, mapped ? "R2" : "R4", "enable in access", 32'(m_penable), 32'(esel));
            if (s_pready) break;
            waited++;
            @(negedge clk);
        end
        chk(waited == (mapped ? r % 3 : 0), mapped ? "R3" : "R4", "wait states", 32'(waited), 32'(mapped ? r % 3 : 0));
        chk(s_prdata == (mapped ? {8'(8'hC0 + r), 12'h000, a} : 32'h0), mapped ? "R3" : "R4",
            "read data", s_prdata, mapped ? {8'(8'hC0 + r), 12'h000, a} : 32'h0);
        chk(s_pslverr == (mapped ? a[2] : 1'b1), mapped ? "R3" : "R4", "error", 32'(s_pslverr), 32'(mapped ? a[2] : 1'b1));
        @(negedge clk);
        s_psel = 1'b0; s_penable = 1'b0;
    endtask

    task automatic do_tmo_setup(input int r);
        @(negedge clk);
        s_paddr = {4'(r), 8'h10}; s_psel = 1'b1; s_penable = 1'b0; tmo_expire_i = 1'b1;
        #1;
        chk(tmo_start_o, "R5", "start with setup expiry", 32'(tmo_start_o), 1);
        chk(m_psel == '0, "R7", "select dropped in setup", 32'(m_psel), 0);
        @(negedge clk);
        tmo_expire_i = 1'b0; s_penable = 1'b1;
        #1;
        chk(s_pready && s_pslverr && s_prdata == 0, "R7", "error completion",
            {s_pready, s_pslverr, 30'(s_prdata)}, 32'hC000_0000);
        chk(m_psel == '0 && m_penable == '0, "R7", "target idle", 32'(m_penable), 0);
        chk(tmo_flags_o == 12'(1 << fbit(r)), "R8", "flag after setup expiry", 32'(tmo_flags_o), 32'(1 << fbit(r)));
        @(negedge clk);
        s_psel = 1'b0; s_penable = 1'b0;
        #1;
        chk(tmo_flags_o == '0, "R8", "flag pulse ends", 32'(tmo_flags_o), 0);
    endtask

    task automatic do_tmo_access(input int r);
        @(negedge clk);
        stall = 1'b1;
        s_paddr = {4'(r), 8'h24}; s_psel = 1'b1; s_penable = 1'b0;
        @(negedge clk);
        s_penable = 1'b1;
        #1;
        chk(!s_pready, "R3", "stalled target holds", 32'(s_pready), 0);
        @(negedge clk);
        tmo_expire_i = 1'b1;
        #1;
        chk(s_pready && s_pslverr && s_prdata == 0, "R6", "access abort completion",
            {s_pready, s_pslverr, 30'(s_prdata)}, 32'hC000_0000);
        chk(m_psel == '0 && m_penable == '0, "R6", "target released", 32'(m_psel), 0);
        @(negedge clk);
        tmo_expire_i = 1'b0; s_psel = 1'b0; s_penable = 1'b0; stall = 1'b0;
        #1;
        chk(tmo_flags_o == 12'(1 << fbit(r)), "R8", "flag after access expiry", 32'(tmo_flags_o), 32'(1 << fbit(r)));
        @(negedge clk);
        #1;
        chk(tmo_flags_o == '0, "R8", "flag clears", 32'(tmo_flags_o), 0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R10: reset holds targets idle even with an active upstream request.
        s_paddr = 12'h200; s_psel = 1'b1; s_penable = 1'b1; tmo_expire_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(m_psel == '0 && m_penable == '0 && !tmo_start_o, "R10", "idle in reset", 32'(m_psel), 0);
        chk(tmo_flags_o == '0, "R10", "flags in reset", 32'(tmo_flags_o), 0);
        s_psel = 1'b0; s_penable = 1'b0; tmo_expire_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R1..R5: every region, both directions.
        for (int r = 0; r < 16; r++) begin
            for (int w = 0; w < 2; w++) begin
                do_xfer({4'(r), 8'(r * 13 + w * 4)}, 1'(w));
            end
        end

        // R6..R8: timeouts on every target in both phases.
        for (int r = 0; r < NT; r++) begin
            do_tmo_setup(r);
            do_tmo_access(r);
        end

        // R9: expiry with no open transfer.
        @(negedge clk);
        tmo_expire_i = 1'b1;
        @(negedge clk);
        tmo_expire_i = 1'b0;
        #1;
        chk(tmo_flags_o == '0, "R9", "idle expiry ignored", 32'(tmo_flags_o), 0);

        // R9: expiry during an unmapped transfer.
        @(negedge clk);
        s_paddr = 12'hC00; s_psel = 1'b1; s_penable = 1'b0;
        @(negedge clk);
        s_penable = 1'b1; tmo_expire_i = 1'b1;
        #1;
        chk(s_pready && s_pslverr, "R9", "unmapped completion", 32'({s_pready, s_pslverr}), 3);
        @(negedge clk);
        s_psel = 1'b0; s_penable = 1'b0; tmo_expire_i = 1'b0;
        #1;
        chk(tmo_flags_o == '0, "R9", "unmapped expiry ignored", 32'(tmo_flags_o), 0);

        // R11: ready and expiry together; expiry wins.
        @(negedge clk);
        s_paddr = 12'h010; s_psel = 1'b1; s_penable = 1'b0;
        @(negedge clk);
        s_penable = 1'b1; tmo_expire_i = 1'b1;
        #1;
        chk(s_pready && s_pslverr, "R11", "expiry beats ready", 32'({s_pready, s_pslverr}), 3);
        @(negedge clk);
        s_psel = 1'b0; s_penable = 1'b0; tmo_expire_i = 1'b0;
        #1;
        chk(tmo_flags_o == 12'h001, "R11", "flag with coincident ready", 32'(tmo_flags_o), 1);

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule